// File: doc/BRIEF.md
# Fax Line Code Framer

The framer sits behind a run-length coder in a facsimile transmit path. It receives, record by record, the variable-length code of each scan line and turns it into a transmittable bit stream. Each line opens with an end-of-line marker (eleven 0 bits, then a 1). In line-skip mode a one-bit white flag follows the marker. Zero fill is then inserted so that every line reaches a programmed minimum length, and an optional zero pad rounds the line to whole bytes. At the end of a page the framer sends a programmed number of back-to-back markers and flushes the last partial byte with zeros. The output is a byte stream with a valid/ready handshake, packed with the first bit in the MSB.

Input records arrive on a single valid/ready channel, and `in_kind` selects the record type: 0 = line start (carries `in_white`), 1 = code chunk, 2 = page end, 3 = ignored. A code chunk holds `in_len` bits, left-aligned in `in_data`, so the first bit sent is `in_data[CW-1]`. `in_last` marks the final chunk of a line. Inside a line every record is taken as code, so a line must end with a chunk that has `in_last` set. In line-skip mode an all-white line sends no run codes: its chunks are consumed and dropped, and the line is filled to half the minimum length. The configuration inputs are sampled while records are processed and should change only while `busy` is low.

The controller is a state machine with these states: IDLE (accepts a record), MARK (pushes the marker), FLAG (pushes the white flag), CODE (passes code chunks), DROP (discards the chunks of a skipped white line), FILL (pushes zeros up to the line goal), PAD (pushes zeros up to a byte boundary), RTC (pushes the page-end markers), FLUSH (pushes zeros up to a byte boundary), DRAIN (waits for the packer to empty) and DONE (one-cycle completion). The transitions are:
- IDLE goes to MARK on a line start, to RTC on a page end, and stays in IDLE on any other record.
- MARK goes to FLAG when skip mode is on and to CODE otherwise.
- FLAG goes to DROP for a white line and to CODE otherwise.
- CODE and DROP go to FILL on the last chunk.
- FILL goes to PAD when the goal is met, and PAD goes to IDLE.
- RTC goes to FLUSH when no markers remain.
- FLUSH goes to DRAIN, DRAIN goes to DONE when the packer is empty, and DONE goes to IDLE.

Top module: `fax_line_framer`

## Requirements
- R1: Every line starts with the 12-bit marker 000000000001 (eleven 0 bits, then a 1), sent before any other bit of that line.
- R2: When the marker, flag and code of a line total fewer bits than `cfg_min_bits`, 0 bits are inserted after the code and before the next marker, so that the line totals exactly `cfg_min_bits`. A longer line gets no fill.
- R3: With `cfg_skip_en` = 1, a single flag bit follows each marker, equal to `in_white` of the line start (1 = all white, 0 = not). For a line that is not white, its code bits follow the flag unchanged.
- R4: With `cfg_skip_en` = 1 and a white line, all code chunks of the line are accepted and dropped. The line totals max(13, floor(`cfg_min_bits`/2)) bits: marker, flag 1, then zeros.
- R5: With `cfg_pad_en` = 1, after fill, 0 bits are appended until the line length is a multiple of 8.
- R6: A page-end record produces exactly `cfg_eop_count` (0 to 255) markers, followed by 0 bits up to the next byte boundary. No bits are added when the stream is already aligned.
- R7: Output bytes carry the earliest bit in bit 7. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold.
- R8: `done` is high for exactly one cycle after the last byte of a page is accepted, and no byte is offered while `done` is high.
- R9: After reset, `out_valid`, `busy` and `done` are low.
- R10: With `cfg_skip_en` = 0, no flag is sent and `in_white` has no effect: code follows the marker directly.
- R11: While `busy` is low, `in_ready` is high.
- R12: Bits of `in_data` below the top `in_len` bits have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min_bits | input | 16 | Minimum bits per line |
| cfg_skip_en | input | 1 | Line-skip mode enable |
| cfg_pad_en | input | 1 | Byte pad per line enable |
| cfg_eop_count | input | 8 | Markers sent at page end |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted |
| in_kind | input | 2 | 0 line start, 1 code, 2 page end, 3 ignored |
| in_white | input | 1 | Line is all white (with line start) |
| in_data | input | CW | Code bits, left-aligned |
| in_len | input | $clog2(CW+1) | Number of valid code bits |
| in_last | input | 1 | Last code chunk of a line |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_byte | output | 8 | Packed output byte |
| busy | output | 1 | Controller not idle |
| done | output | 1 | Page complete pulse |

## Verification
The bench aims at the points where the line length meets a goal:
- A line whose code alone exceeds the minimum would gain bits from a framer that fills unconditionally.
- A white skipped line whose half-minimum falls below 13 would come out short, or leave a stray bit, if the clamp were missing.
- A page end on an already aligned stream with zero markers would add a spurious byte, or never pulse `done`, if the flush or drain ends were off by one.

Downstream stalls on a fixed pattern show whether a byte changes while it is held. Garbage below each chunk's length shows whether the code mask leaks bits.

// File: rtl/fax_frm_pkg.sv
package fax_frm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MARK,
        ST_FLAG,
        ST_CODE,
        ST_DROP,
        ST_FILL,
        ST_PAD,
        ST_RTC,
        ST_FLUSH,
        ST_DRAIN,
        ST_DONE
    } frm_state_e;

    localparam logic [1:0] REC_LINE = 2'd0;
    localparam logic [1:0] REC_CODE = 2'd1;
    localparam logic [1:0] REC_PAGE = 2'd2;

    localparam int MARK_BITS = 12;
    localparam int SKIP_FLOOR = MARK_BITS + 1;

endpackage

// File: rtl/frm_goal.sv
// Works out how many zeros a line still needs: fill up to the minimum goal,
// then pad to a byte boundary.
module frm_goal #(
    parameter int LBW = 20
) (
    input  logic [15:0]    min_bits,
    input  logic           half_mode,
    input  logic           pad_en,
    input  logic [LBW-1:0] line_bits,
    output logic [LBW-1:0] fill_rem,
    output logic [3:0]     pad_rem
);
    import fax_frm_pkg::*;

    logic [LBW-1:0] full_goal;
    logic [LBW-1:0] half_goal;
    logic [LBW-1:0] goal;

    always_comb begin
        full_goal = LBW'(min_bits);
        half_goal = LBW'(min_bits >> 1);
        if (half_mode) begin
            goal = (half_goal > LBW'(SKIP_FLOOR)) ? half_goal : LBW'(SKIP_FLOOR);
        end else begin
            goal = full_goal;
        end
        fill_rem = (goal > line_bits) ? (goal - line_bits) : '0;
        if (pad_en && (line_bits[2:0] != 3'd0)) begin
            pad_rem = 4'd8 - {1'b0, line_bits[2:0]};
        end else begin
            pad_rem = 4'd0;
        end
    end

endmodule

// File: rtl/frm_pack.sv
// Bit packer: accepts left-aligned chunks of up to CW bits and emits bytes
// with the first bit in the MSB.
module frm_pack #(
    parameter int CW = 16,
    localparam int LENW = $clog2(CW + 1),
    localparam int ACCW = CW + 8,
    localparam int CNTW = $clog2(ACCW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ps_valid,
    input  logic [CW-1:0]   ps_data,
    input  logic [LENW-1:0] ps_len,
    output logic            ps_ready,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_byte,
    output logic            empty
);
    logic [ACCW-1:0] acc_q, acc_s, acc_d;
    logic [CNTW-1:0] cnt_q, cnt_s, cnt_d;
    logic            pop, fire;

    assign out_valid = (cnt_q >= CNTW'(8));
    assign out_byte  = acc_q[ACCW-1 -: 8];
    assign ps_ready  = (cnt_q <= CNTW'(8));
    assign empty     = (cnt_q == '0);

    always_comb begin
        pop   = out_valid && out_ready;
        fire  = ps_valid && ps_ready;
        acc_s = pop ? (acc_q << 8) : acc_q;
        cnt_s = pop ? (cnt_q - CNTW'(8)) : cnt_q;
        acc_d = acc_s;
        cnt_d = cnt_s;
        if (fire) begin
            acc_d = acc_s | ({ps_data, 8'h00} >> cnt_s);
            cnt_d = cnt_s + CNTW'(ps_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/frm_seq.sv
// Framing sequencer: decides which bits go into the packer and when.
module frm_seq #(
    parameter int CW = 16,
    parameter int LBW = 20,
    localparam int LENW = $clog2(CW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     cfg_min_bits,
    input  logic            cfg_skip_en,
    input  logic            cfg_pad_en,
    input  logic [7:0]      cfg_eop_count,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_kind,
    input  logic            in_white,
    input  logic [CW-1:0]   in_data,
    input  logic [LENW-1:0] in_len,
    input  logic            in_last,
    output logic            ps_valid,
    output logic [CW-1:0]   ps_data,
    output logic [LENW-1:0] ps_len,
    input  logic            ps_ready,
    input  logic            pk_empty,
    output logic            busy,
    output logic            done
);
    import fax_frm_pkg::*;

    localparam logic [CW-1:0] MARK_WORD = {{(CW-1){1'b0}}, 1'b1} << (CW - MARK_BITS);
    localparam logic [CW-1:0] ONES = {CW{1'b1}};

    frm_state_e     state_q, state_d;
    logic [LBW-1:0] line_bits_q;
    logic           white_q;
    logic [7:0]     rtc_q;
    logic [2:0]     pos_q;

    logic [LBW-1:0] fill_rem;
    logic [3:0]     pad_rem;
    logic [LENW-1:0] fill_len;
    logic           fire, take;

    frm_goal #(.LBW(LBW)) u_goal (
        .min_bits  (cfg_min_bits),
        .half_mode (white_q),
        .pad_en    (cfg_pad_en),
        .line_bits (line_bits_q),
        .fill_rem  (fill_rem),
        .pad_rem   (pad_rem)
    );

    assign fill_len = (fill_rem > LBW'(CW)) ? LENW'(CW) : fill_rem[LENW-1:0];
    assign fire = ps_valid && ps_ready;
    assign take = in_valid && in_ready;

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            line_bits_q <= '0;
            white_q     <= 1'b0;
            rtc_q       <= '0;
            pos_q       <= '0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                pos_q <= pos_q + ps_len[2:0];
                if (state_q == ST_MARK) begin
                    line_bits_q <= LBW'(MARK_BITS);
                end else begin
                    line_bits_q <= line_bits_q + LBW'(ps_len);
                end
            end
            if (state_q == ST_IDLE && take && in_kind == REC_LINE) begin
                white_q <= cfg_skip_en && in_white;
            end
            if (state_q == ST_IDLE && take && in_kind == REC_PAGE) begin
                rtc_q <= cfg_eop_count;
            end else if (state_q == ST_RTC && fire) begin
                rtc_q <= rtc_q - 8'd1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && in_kind == REC_LINE) state_d = ST_MARK;
                else if (take && in_kind == REC_PAGE) state_d = ST_RTC;
            end
            ST_MARK:  if (fire) state_d = cfg_skip_en ? ST_FLAG : ST_CODE;
            ST_FLAG:  if (fire) state_d = white_q ? ST_DROP : ST_CODE;
            ST_CODE:  if (take && in_last) state_d = ST_FILL;
            ST_DROP:  if (take && in_last) state_d = ST_FILL;
            ST_FILL:  if (fill_rem == '0) state_d = ST_PAD;
            ST_PAD:   if (pad_rem == 4'd0 || fire) state_d = ST_IDLE;
            ST_RTC:   if (rtc_q == 8'd0) state_d = ST_FLUSH;
            ST_FLUSH: if (pos_q == 3'd0 || fire) state_d = ST_DRAIN;
            ST_DRAIN: if (pk_empty) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ps_valid = 1'b0;
        ps_data  = '0;
        ps_len   = '0;
        in_ready = 1'b0;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_MARK: begin
                ps_valid = 1'b1;
                ps_data  = MARK_WORD;
                ps_len   = LENW'(MARK_BITS);
            end
            ST_FLAG: begin
                ps_valid = 1'b1;
                ps_data  = {white_q, {(CW-1){1'b0}}};
                ps_len   = LENW'(1);
            end
            ST_CODE: begin
                in_ready = ps_ready;
                ps_valid = in_valid;
                ps_data  = in_data & ~(ONES >> in_len);
                ps_len   = in_len;
            end
            ST_DROP: in_ready = 1'b1;
            ST_FILL: begin
                ps_valid = (fill_rem != '0);
                ps_len   = fill_len;
            end
            ST_PAD: begin
                ps_valid = (pad_rem != 4'd0);
                ps_len   = LENW'(pad_rem);
            end
            ST_RTC: begin
                ps_valid = (rtc_q != 8'd0);
                ps_data  = MARK_WORD;
                ps_len   = LENW'(MARK_BITS);
            end
            ST_FLUSH: begin
                ps_valid = (pos_q != 3'd0);
                ps_len   = LENW'(4'd8 - {1'b0, pos_q});
            end
            ST_DRAIN: ;
            ST_DONE:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fax_line_framer.sv
module fax_line_framer #(
    parameter int CW = 16,
    parameter int LBW = 20,
    localparam int LENW = $clog2(CW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     cfg_min_bits,
    input  logic            cfg_skip_en,
    input  logic            cfg_pad_en,
    input  logic [7:0]      cfg_eop_count,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_kind,
    input  logic            in_white,
    input  logic [CW-1:0]   in_data,
    input  logic [LENW-1:0] in_len,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_byte,
    output logic            busy,
    output logic            done
);
    logic            ps_valid, ps_ready, pk_empty;
    logic [CW-1:0]   ps_data;
    logic [LENW-1:0] ps_len;

    frm_seq #(.CW(CW), .LBW(LBW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_min_bits  (cfg_min_bits),
        .cfg_skip_en   (cfg_skip_en),
        .cfg_pad_en    (cfg_pad_en),
        .cfg_eop_count (cfg_eop_count),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_kind       (in_kind),
        .in_white      (in_white),
        .in_data       (in_data),
        .in_len        (in_len),
        .in_last       (in_last),
        .ps_valid      (ps_valid),
        .ps_data       (ps_data),
        .ps_len        (ps_len),
        .ps_ready      (ps_ready),
        .pk_empty      (pk_empty),
        .busy          (busy),
        .done          (done)
    );

    frm_pack #(.CW(CW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_valid  (ps_valid),
        .ps_data   (ps_data),
        .ps_len    (ps_len),
        .ps_ready  (ps_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .empty     (pk_empty)
    );

endmodule

// File: rtl/frm_chk.sv
module frm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       in_ready,
    input logic       busy,
    input logic       done,
    input logic       pk_empty
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)))
        else $error("R7 byte not held under stall");

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R8 done longer than one cycle");

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && pk_empty))
        else $error("R8 byte offered while done");

    p_idle_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready)
        else $error("R11 idle without ready");

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("R8 done outside a page sequence");
endmodule

bind fax_line_framer frm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .in_ready  (in_ready),
    .busy      (busy),
    .done      (done),
    .pk_empty  (pk_empty)
);

// File: tb/sim_fax_line_framer.sv
`timescale 1ns/1ps
module sim_fax_line_framer;
    localparam int CW = 16;
    localparam int LENW = $clog2(CW + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     cfg_min_bits = '0;
    logic            cfg_skip_en = 1'b0;
    logic            cfg_pad_en = 1'b0;
    logic [7:0]      cfg_eop_count = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [1:0]      in_kind = '0;
    logic            in_white = 1'b0;
    logic [CW-1:0]   in_data = '0;
    logic [LENW-1:0] in_len = '0;
    logic            in_last = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [7:0]      out_byte;
    logic            busy, done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit stall_en = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_byte = '0;

    bit got[$];
    bit exp[$];
    int lb;
    bit drop;

    always #5 clk = ~clk;

    fax_line_framer #(.CW(CW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Output monitor: set ready, then capture handshakes that occur at next edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && prev_stall)
            chk(out_valid && out_byte == prev_byte, "R7 hold", int'(out_byte), int'(prev_byte));
        out_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
        prev_stall = rst_n && out_valid && !out_ready;
        prev_byte = out_byte;
        if (rst_n && out_valid && out_ready)
            for (int i = 7; i >= 0; i--) got.push_back(out_byte[i]);
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_rec(input logic [1:0] k, input bit w, input logic [CW-1:0] d,
                            input int len, input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_white = w; in_data = d;
        in_len = LENW'(len); in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic add_bits(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) exp.push_back(v[i]);
    endtask

    task automatic begin_line(input bit white);
        send_rec(2'd0, white, '0, 0, 1'b0);
        add_bits(1, 12);
        lb = 12;
        drop = 1'b0;
        if (cfg_skip_en) begin
            exp.push_back(white);
            lb = 13;
            drop = white;
        end
    endtask

    task automatic code(input int v, input int len, input bit last);
        logic [CW-1:0] d;
        int goal;
        d = CW'(v << (CW - len)) | (({CW{1'b1}} >> len) & 16'h5A5A); // R12 junk below
        send_rec(2'd1, 1'b0, d, len, last);
        if (!drop) begin
            add_bits(v, len);
            lb += len;
        end
        if (last) begin
            goal = drop ? ((cfg_min_bits / 2 > 13) ? cfg_min_bits / 2 : 13) : int'(cfg_min_bits);
            while (lb < goal) begin exp.push_back(1'b0); lb++; end
            if (cfg_pad_en) while (lb % 8 != 0) begin exp.push_back(1'b0); lb++; end
        end
    endtask

    task automatic end_page(input int n, input string req);
        int t;
        int errs;
        cfg_eop_count = 8'(n);
        send_rec(2'd2, 1'b0, '0, 0, 1'b0);
        for (int i = 0; i < n; i++) add_bits(1, 12);
        while (exp.size() % 8 != 0) exp.push_back(1'b0);
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        chk(done == 1'b1, {req, " R8 done seen"}, int'(done), 1);
        chk(busy == 1'b1, "R8 busy during done", int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
        chk(got.size() == exp.size(), {req, " length"}, got.size(), exp.size());
        errs = 0;
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            if (got[i] != exp[i]) errs++;
        chk(errs == 0, {req, " bit content"}, errs, 0);
    endtask

    task automatic clear_page();
        got.delete();
        exp.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid, "R9 out_valid", int'(out_valid), 0);
        chk(!busy, "R9 busy", int'(busy), 0);
        chk(!done, "R9 done", int'(done), 0);
        chk(in_ready, "R11 idle ready", int'(in_ready), 1);
    endtask

    task automatic t_plain();
        clear_page();
        cfg_min_bits = 0; cfg_skip_en = 0; cfg_pad_en = 0;
        begin_line(1'b0);
        code(5'b10110, 5, 1'b0);
        code(3'b011, 3, 1'b1);
        end_page(2, "R6 R12 plain");
        chk(got.size() == 48, "R6 flush to byte", got.size(), 48);
        chk(got.size() >= 12 && got[11] == 1'b1 && got[10] == 1'b0 && got[0] == 1'b0,
            "R1 marker", got.size() >= 12 ? int'(got[11]) : -1, 1);
        chk(got.size() >= 17 && got[12] == 1'b1 && got[16] == 1'b0, "R7 MSB first order",
            got.size() >= 17 ? int'(got[12]) : -1, 1);
    endtask

    task automatic t_minfill();
        clear_page();
        cfg_min_bits = 40; cfg_skip_en = 0; cfg_pad_en = 0;
        begin_line(1'b0);
        code(10'h2C5, 10, 1'b1);
        begin_line(1'b0);
        code(16'hF00F, 16, 1'b0);
        code(16'h1234, 16, 1'b0);
        code(8'hA5, 8, 1'b1);
        end_page(1, "R2 min fill");
        chk(got.size() == 104, "R2 long line gets no fill", got.size(), 104);
    endtask

    task automatic t_skip();
        clear_page();
        cfg_min_bits = 60; cfg_skip_en = 1; cfg_pad_en = 0;
        begin_line(1'b0);
        code(6'b110101, 6, 1'b1);
        begin_line(1'b1);
        code(16'hFFFF, 16, 1'b0);
        code(4'hF, 4, 1'b1);
        end_page(3, "R3 R4 skip");
        chk(got.size() > 12 && got[12] == 1'b0, "R3 flag non-white", got.size() > 12 ? int'(got[12]) : -1, 0);
        chk(got.size() > 72 && got[72] == 1'b1, "R4 flag white", got.size() > 72 ? int'(got[72]) : -1, 1);
        chk(got.size() == 128, "R4 half-minimum length", got.size(), 128);
    endtask

    task automatic t_skip_small();
        clear_page();
        cfg_min_bits = 10; cfg_skip_en = 1; cfg_pad_en = 0;
        begin_line(1'b1);
        code(5'h1F, 5, 1'b1);
        cfg_skip_en = 0;
        begin_line(1'b1);
        code(4'b1001, 4, 1'b1);
        end_page(0, "R4 R10 floor");
        chk(got.size() == 32, "R10 no flag when skip off", got.size(), 32);
        chk(got.size() > 25 && got[25] == 1'b1 && got[24] == 1'b1, "R10 code after marker",
            got.size() > 25 ? int'(got[25]) : -1, 1);
    endtask

    task automatic t_pad();
        clear_page();
        cfg_min_bits = 0; cfg_skip_en = 0; cfg_pad_en = 1;
        begin_line(1'b0);
        code(7'h55, 7, 1'b1);
        begin_line(1'b0);
        code(16'hC3C3, 16, 1'b0);
        code(4'h9, 4, 1'b1);
        end_page(0, "R5 pad");
        chk(got.size() == 56, "R6 aligned page adds nothing", got.size(), 56);
    endtask

    task automatic t_stall();
        clear_page();
        stall_en = 1'b1;
        cfg_min_bits = 50; cfg_skip_en = 1; cfg_pad_en = 1;
        for (int l = 0; l < 4; l++) begin
            begin_line(l == 2);
            code(16'h8001 + l, 16, 1'b0);
            code(16'h7E7E, 16, 1'b0);
            code(3'b101, 3, 1'b1);
        end
        end_page(5, "R7 stall");
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_minfill();
        t_skip();
        t_skip_small();
        t_pad();
        t_stall();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule